// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit of a small non-pipelined processor. It owns the program counter (PC), the memory address register (MAR), the memory data register (MDR), the instruction register (IR) and an operand register. Each instruction passes through its phases one after another, and the next instruction starts only after the current one has fully finished. The phases are fetch, decode, an optional operand read, execute and an optional result write.

All memory traffic uses one shared port. The sequencer raises chip-enable together with a direction bit, and it holds the request until the memory answers with an acknowledge. Execution is handed to an external ALU. The sequencer sends a one-cycle start pulse, then waits for a done pulse and latches the returned result.

A fixed decode table works on the top bits of the instruction word. It decides whether an operand is read from memory, whether the result is written to memory, and how the effective address (EA) is formed.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, `mem_ce`, `alu_start` and `instr_done` are 0. On the first clock edge after reset is released, a read is issued at address 0x0000, so `mem_ce`=1 and `mem_addr`=0 from that edge onward.
- R2: A request keeps `mem_ce`=1 and holds `mem_addr` and `mem_rw` unchanged until `mem_ack`=1. With an acknowledge latency of L cycles, the access completes L cycles after `mem_ce` rises.
- R3: `mem_ce` returns to 0 on the clock edge that samples `mem_ack`=1.
- R4: Instruction fetches are reads (`mem_rw`=1), and each fetch is made at the previous fetch address plus one.
- R5: Instruction word bits [7:6] select the class. 00 has no memory operand and no memory result. 01 reads an operand. 10 writes the result. 11 reads an operand and writes the result back.
- R6: Bit 5 of the instruction selects the EA. When it is 0, EA = DATA_BASE (0x0100) + bits [4:0]. When it is 1, EA = the address of the next instruction + bits [4:0].
- R7: For classes 01 and 11, a read at the EA is made after the fetch. The data read is presented on `alu_a`. `alu_a` keeps the most recent operand, and it is 0 after reset.
- R8: A phase that is skipped costs no cycle. For class 00, `alu_start` is high in the third cycle after the cycle in which the fetch acknowledge is given.
- R9: `alu_start` is a one-cycle pulse, once per instruction, with `alu_op` equal to the instruction word.
- R10: For classes 10 and 11, a write (`mem_rw`=0) is made at the EA, and `mem_wdata` equals the ALU result that was latched for that instruction.
- R11: `instr_done` pulses for exactly one cycle per instruction, and the next fetch request follows it directly.
- R12: `mem_ce` stays 0 from `alu_start` until the ALU done pulse has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W (16) | Memory address, driven from MAR |
| mem_ce | output | 1 | Chip-enable, registered |
| mem_rw | output | 1 | 1 = read, 0 = write, registered |
| mem_wdata | output | DATA_W (8) | Write data |
| mem_rdata | input | DATA_W (8) | Read data, valid with the acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| alu_start | output | 1 | Execute start pulse |
| alu_op | output | DATA_W (8) | Current instruction word |
| alu_a | output | DATA_W (8) | Operand register |
| alu_done | input | 1 | ALU completion pulse |
| alu_result | input | DATA_W (8) | ALU result, valid with `alu_done` |
| instr_done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
Two functions can meet in one cycle. The first is the acknowledge that ends a result write. The second is the completion pulse together with the launch of the next fetch. The bench runs a program with every class and both address modes. It does this with memory latencies of 0, 1 and 3, so the write acknowledge sometimes lands right after the ALU done pulse and sometimes several cycles later. A negative-edge monitor then checks each case. It confirms that chip-enable drops after every acknowledge. It confirms that the done pulse lasts one cycle and is followed by a fetch at the next sequential address. It also confirms that the write data and address match the values worked out from the decode rules.

// File: rtl/icsq_pkg.sv
package icsq_pkg;

   typedef enum logic [2:0] {
      PH_IF_ADDR,
      PH_IF_WAIT,
      PH_IF_IR,
      PH_DECODE,
      PH_OF_WAIT,
      PH_EX_START,
      PH_EX_WAIT,
      PH_ST_WAIT
   } phase_t;

   typedef struct packed {
      logic need_opnd;
      logic to_mem;
      logic ea_rel;
   } dec_t;

endpackage

// File: rtl/icsq_decode.sv
module icsq_decode
   import icsq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned OFS_W     = 5,
   parameter int unsigned DATA_BASE = 'h100,
   parameter bit          REL_EN    = 1'b1
) (
   input  logic [DATA_W-1:0] ir,
   input  logic [ADDR_W-1:0] pc,
   output dec_t              dec,
   output logic [ADDR_W-1:0] ea
);
   localparam int unsigned CLS_HI  = DATA_W - 1;
   localparam int unsigned MODE_B  = DATA_W - 3;
   localparam int unsigned PAD_W   = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] base_abs;

   assign ofs_ext  = {{PAD_W{1'b0}}, ir[OFS_W-1:0]};
   assign base_abs = ADDR_W'(DATA_BASE);

   assign dec.need_opnd = ir[CLS_HI-1];
   assign dec.to_mem    = ir[CLS_HI];

   generate
      if (REL_EN) begin : g_rel
         assign dec.ea_rel = ir[MODE_B];
         assign ea = ir[MODE_B] ? (pc + ofs_ext) : (base_abs + ofs_ext);
      end else begin : g_abs
         logic unused_rel;
         assign unused_rel = ^{pc, ir[MODE_B]};
         assign dec.ea_rel = 1'b0;
         assign ea = base_abs + ofs_ext;
      end
   endgenerate

endmodule

// File: rtl/icsq_ctrl.sv
module icsq_ctrl
   import icsq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dec_t              dec,
   input  logic [ADDR_W-1:0] ea,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce,
   output logic              mem_rw,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              alu_start,
   output logic [DATA_W-1:0] alu_a,
   input  logic              alu_done,
   input  logic [DATA_W-1:0] alu_result,
   output logic              instr_done
);
   phase_t            ph;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mdr_q, ir_q, opnd_q, res_q;
   logic              ce_q, rw_q, done_q;
   logic              unused_dec;

   assign unused_dec = dec.ea_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IF_ADDR;
         pc_q   <= '0;
         mar_q  <= '0;
         mdr_q  <= '0;
         ir_q   <= '0;
         opnd_q <= '0;
         res_q  <= '0;
         ce_q   <= 1'b0;
         rw_q   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (ph)
            PH_IF_ADDR: begin
               mar_q <= pc_q;
               ce_q  <= 1'b1;
               rw_q  <= 1'b1;
               ph    <= PH_IF_WAIT;
            end
            PH_IF_WAIT: if (mem_ack) begin
               mdr_q <= mem_rdata;
               ce_q  <= 1'b0;
               ph    <= PH_IF_IR;
            end
            PH_IF_IR: begin
               ir_q <= mdr_q;
               pc_q <= pc_q + 1'b1;
               ph   <= PH_DECODE;
            end
            PH_DECODE: begin
               if (dec.need_opnd) begin
                  mar_q <= ea;
                  ce_q  <= 1'b1;
                  rw_q  <= 1'b1;
                  ph    <= PH_OF_WAIT;
               end else begin
                  ph <= PH_EX_START;
               end
            end
            PH_OF_WAIT: if (mem_ack) begin
               opnd_q <= mem_rdata;
               ce_q   <= 1'b0;
               ph     <= PH_EX_START;
            end
            PH_EX_START: ph <= PH_EX_WAIT;
            PH_EX_WAIT: if (alu_done) begin
               res_q <= alu_result;
               if (dec.to_mem) begin
                  mar_q <= ea;
                  ce_q  <= 1'b1;
                  rw_q  <= 1'b0;
                  ph    <= PH_ST_WAIT;
               end else begin
                  done_q <= 1'b1;
                  ph     <= PH_IF_ADDR;
               end
            end
            PH_ST_WAIT: if (mem_ack) begin
               ce_q   <= 1'b0;
               rw_q   <= 1'b1;
               done_q <= 1'b1;
               ph     <= PH_IF_ADDR;
            end
            default: ph <= PH_IF_ADDR;
         endcase
      end
   end

   assign ir         = ir_q;
   assign pc         = pc_q;
   assign mem_addr   = mar_q;
   assign mem_ce     = ce_q;
   assign mem_rw     = rw_q;
   assign mem_wdata  = res_q;
   assign alu_start  = (ph == PH_EX_START);
   assign alu_a      = opnd_q;
   assign instr_done = done_q;

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce && !mem_ack) |=> (mem_ce && $stable(mem_addr) && $stable(mem_rw)));

   // R3
   ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce && mem_ack) |=> !mem_ce);

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_start |=> !alu_start);

   // R12
   exec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_start |-> !mem_ce);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |=> (!instr_done && mem_ce && mem_rw));

   // R10
   store_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce && !mem_rw && mem_ack) |=> instr_done);

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
   import icsq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned OFS_W     = 5,
   parameter int unsigned DATA_BASE = 'h100,
   parameter bit          REL_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce,
   output logic              mem_rw,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              alu_start,
   output logic [DATA_W-1:0] alu_op,
   output logic [DATA_W-1:0] alu_a,
   input  logic              alu_done,
   input  logic [DATA_W-1:0] alu_result,
   output logic              instr_done
);
   generate
      if (DATA_W < OFS_W + 3) begin : g_bad_data_w
         $error("instr_cycle_seq: DATA_W too small for class, mode and offset fields");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr_w
         $error("instr_cycle_seq: ADDR_W must exceed OFS_W");
      end
   endgenerate

   dec_t              dec;
   logic [ADDR_W-1:0] ea, pc;
   logic [DATA_W-1:0] ir;

   icsq_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
      .DATA_BASE(DATA_BASE), .REL_EN(REL_EN)
   ) u_dec (
      .ir(ir), .pc(pc), .dec(dec), .ea(ea)
   );

   icsq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dec(dec), .ea(ea), .ir(ir), .pc(pc),
      .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_rw(mem_rw),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .alu_start(alu_start), .alu_a(alu_a), .alu_done(alu_done),
      .alu_result(alu_result), .instr_done(instr_done)
   );

   assign alu_op = ir;

endmodule

// File: tb/tb_instr_cycle_seq.sv
`timescale 1ns/1ps
module tb_instr_cycle_seq;
   localparam int NPROG = 8;
   localparam logic [7:0] PROG [NPROG] = '{8'h05, 8'h43, 8'h82, 8'hC4,
                                           8'h61, 8'hA2, 8'hFF, 8'h1F};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] mem_addr;
   logic mem_ce, mem_rw, mem_ack, alu_start, alu_done, instr_done;
   logic [7:0] mem_wdata, mem_rdata, alu_op, alu_a, alu_result;

   always #5 clk = ~clk;

   instr_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_ce(mem_ce),
      .mem_rw(mem_rw), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .alu_start(alu_start), .alu_op(alu_op),
      .alu_a(alu_a), .alu_done(alu_done), .alu_result(alu_result),
      .instr_done(instr_done)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] mem [512];
   logic [7:0] exp_mem [512];
   int mem_lat = 1, wcnt = 0, cyc = 0, first_ce = -1;
   int n_acc = 0, n_st = 0, done_cnt = 0;
   int drop_err = 0, quiet_err = 0, pulse_err = 0;
   logic [15:0] acc_addr [256];
   logic        acc_rw   [256];
   logic [7:0]  acc_data [256];
   int          acc_cyc  [256];
   logic [7:0]  st_op [64];
   logic [7:0]  st_a  [64];
   int          st_cyc [64];
   logic alu_busy = 1'b0, done_prev = 1'b0;
   int acnt = 0;
   logic [7:0] a_lat, op_lat;

   initial begin
      mem_ack = 1'b0; mem_rdata = '0; alu_done = 1'b0; alu_result = '0;
   end

   // memory, ALU and monitor; all work done at the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; wcnt = 0; alu_done = 1'b0; alu_busy = 1'b0; done_prev = 1'b0;
      end else begin
         cyc++;
         if (mem_ack && mem_ce) drop_err++;
         if ((alu_busy || alu_start) && mem_ce) quiet_err++;
         if (instr_done && done_prev) pulse_err++;
         if (instr_done) done_cnt++;
         done_prev = instr_done;
         if (mem_ce && first_ce < 0) first_ce = cyc;
         if (alu_start && n_st < 64) begin
            st_op[n_st] = alu_op; st_a[n_st] = alu_a; st_cyc[n_st] = cyc; n_st++;
         end
         // memory responder
         if (mem_ce && !mem_ack) begin
            if (wcnt == mem_lat) begin
               mem_ack = 1'b1; wcnt = 0;
               if (mem_rw) mem_rdata = mem[mem_addr[8:0]];
               else mem[mem_addr[8:0]] = mem_wdata;
               if (n_acc < 256) begin
                  acc_addr[n_acc] = mem_addr; acc_rw[n_acc] = mem_rw;
                  acc_data[n_acc] = mem_rw ? mem_rdata : mem_wdata;
                  acc_cyc[n_acc] = cyc; n_acc++;
               end
            end else wcnt++;
         end else mem_ack = 1'b0;
         // ALU responder, result = a + op, two-cycle latency
         if (alu_done) alu_done = 1'b0;
         else if (alu_busy) begin
            if (acnt == 0) begin
               alu_done = 1'b1; alu_result = a_lat + op_lat; alu_busy = 1'b0;
            end else acnt--;
         end
         if (alu_start && !alu_busy && !alu_done) begin
            alu_busy = 1'b1; acnt = 1; a_lat = alu_a; op_lat = alu_op;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_mem();
      for (int k = 0; k < 512; k++) mem[k] = 8'h00;
      for (int k = 0; k < NPROG; k++) mem[k] = PROG[k];
      mem[9'h103] = 8'h11; mem[9'h104] = 8'h20; mem[38] = 8'h07;
      for (int k = 0; k < 512; k++) exp_mem[k] = mem[k];
   endtask

   task automatic run_program(input int lat);
      logic [7:0] ir, opnd, res;
      logic [15:0] ea;
      int ai, fcyc;
      rst_n = 1'b0;
      mem_lat = lat;
      repeat (3) @(negedge clk);
      chk(mem_ce == 1'b0 && alu_start == 1'b0 && instr_done == 1'b0,
          "R1 reset outputs idle", {mem_ce, alu_start, instr_done}, 0);
      load_mem();
      n_acc = 0; n_st = 0; done_cnt = 0; cyc = 0; first_ce = -1;
      drop_err = 0; quiet_err = 0; pulse_err = 0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(mem_ce == 1'b1 && mem_addr == 16'h0000, "R1 first fetch at 0",
          {mem_ce, mem_addr}, 32'h10000);
      wait (done_cnt == NPROG);
      @(negedge clk);
      chk(acc_cyc[0] - first_ce == lat, "R2 request held for latency",
          acc_cyc[0] - first_ce, lat);
      // walk the program table and compare with the access log
      opnd = 8'h00; ai = 0;
      for (int i = 0; i < NPROG; i++) begin
         ir = PROG[i];
         chk(acc_addr[ai] == 16'(i) && acc_rw[ai] == 1'b1, "R4 fetch address",
             acc_addr[ai], i);
         fcyc = acc_cyc[ai]; ai++;
         ea = ir[5] ? 16'(i + 1 + ir[4:0]) : 16'(16'h100 + ir[4:0]);
         if (ir[6]) begin
            chk(acc_addr[ai] == ea && acc_rw[ai] == 1'b1, "R5 R6 operand read at EA",
                acc_addr[ai], ea);
            opnd = exp_mem[ea[8:0]];
            ai++;
         end
         chk(st_op[i] == ir, "R9 alu_op is instruction", st_op[i], ir);
         chk(st_a[i] == opnd, "R7 operand on alu_a", st_a[i], opnd);
         if (ir[7:6] == 2'b00)
            chk(st_cyc[i] - fcyc == 3, "R8 skip costs no cycle", st_cyc[i] - fcyc, 3);
         res = opnd + ir;
         if (ir[7]) begin
            chk(acc_addr[ai] == ea && acc_rw[ai] == 1'b0 && acc_data[ai] == res,
                "R10 R5 result write", {acc_addr[ai], acc_data[ai]}, {ea, res});
            exp_mem[ea[8:0]] = res;
            ai++;
         end
      end
      chk(n_st >= NPROG, "R9 one start per instruction", n_st, NPROG);
      chk(drop_err == 0, "R3 ce dropped after ack", drop_err, 0);
      chk(quiet_err == 0, "R12 no access during execute", quiet_err, 0);
      chk(pulse_err == 0, "R11 done is one cycle", pulse_err, 0);
      chk(done_cnt == NPROG, "R11 one done per instruction", done_cnt, NPROG);
   endtask

   initial begin
      run_program(1);
      run_program(0);
      run_program(3);
      // reset in the middle of an instruction restarts at 0
      repeat (5) @(negedge clk);
      run_program(2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule